// File: doc/BRIEF.md
# Pointer Address Generator for Data-Space Loads and Stores

This block forms the data-space address for every load, store, push and pop that a small RISC microcontroller core executes. The core's working registers, its I/O registers, an extended I/O window and its SRAM share one linear byte address space. The block takes an operation kind, a pointer select, a pointer mode, a data register index and a short I/O index. It reads a 16-bit pointer out of a register pair and computes the effective address. It then routes the access either to the register file or to a unified data bus, and writes the adjusted pointer back.

The block also owns the stack pointer, which push and pop step through SRAM. The register file itself, the ALU and instruction decode live outside. The block reaches the register file through three read ports and two write paths: a byte-wide data write, and a pointer write with one enable per byte. Every operation takes a fixed two cycles. A new operation can be accepted in the second cycle of the one before it.

Top module: `ptr_agu`

## Requirements
- R1: A short-form I/O operation (kind 4 = in, kind 5 = out) with index n drives data address n + 0x20. Out writes the source register to the bus. In loads the bus byte into the destination register.
- R2: Pointer select 0, 1 and 2 use register pairs 26/27, 28/29 and 30/31, with the low byte in the even register. In plain mode (mode 0), a load (kind 0) or store (kind 1) uses the pair value as the address and does not write the pointer back.
- R3: In pre-decrement mode (mode 1), the address is the pointer minus one, and that same value is written back to the pair.
- R4: In post-increment mode (mode 2), the address is the unmodified pointer, and the pointer plus one is written back to the pair.
- R5: An operation is accepted when op_valid is high at a rising edge while op_ready is high. op_ready is low in the first cycle after acceptance. The bus strobes and all register-file writes occur only in the second cycle, and their results are in place after that cycle's closing edge.
- R6: Effective addresses 0x0000 to 0x001F select working register n. A load reads that register and a store writes it through the register-file ports, with no bus strobe.
- R7: Addresses at or above the end of the implemented SRAM (0x0500 by default) raise no bus strobe. A load from such an address returns zero, and a store to it changes nothing.
- R8: After reset the stack pointer holds the top SRAM byte (0x04FF). A push (kind 2) writes the source register at the stack pointer, then decrements it.
- R9: A pop (kind 3) increments the stack pointer, then loads the byte at the new value into the destination register.
- R10: When a load's destination register is one byte of the pointer pair being written back, that register receives the loaded byte. The other byte of the pair still receives its updated value.
- R11: op_valid presented while op_ready is low is ignored and starts no access.
- R12: Pointer arithmetic wraps modulo 2^16: pre-decrement from 0x0000 addresses 0xFFFF and leaves 0xFFFF in the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 3 | 0 load, 1 store, 2 push, 3 pop, 4 in, 5 out |
| op_ptr | input | 2 | Pointer pair select |
| op_mode | input | 2 | 0 plain, 1 pre-decrement, 2 post-increment |
| op_reg | input | 5 | Destination or source register |
| op_io | input | 5 | Short I/O index |
| op_ready | output | 1 | Request may be accepted this cycle |
| rf_ptr_lo_addr | output | 5 | Register holding pointer low byte |
| rf_ptr_hi_addr | output | 5 | Register holding pointer high byte |
| rf_ptr_lo_data | input | 8 | Pointer low byte |
| rf_ptr_hi_data | input | 8 | Pointer high byte |
| rf_rd_addr | output | 5 | General register read index |
| rf_rd_data | input | 8 | General register read data |
| rf_dw_en | output | 1 | Data register write enable |
| rf_dw_addr | output | 5 | Data register write index |
| rf_dw_data | output | 8 | Data register write value |
| rf_pw_lo_en | output | 1 | Pointer low byte write enable |
| rf_pw_hi_en | output | 1 | Pointer high byte write enable |
| rf_pw_data | output | 16 | Updated pointer value |
| bus_addr | output | 16 | Data bus address |
| bus_re | output | 1 | Data bus read strobe |
| bus_we | output | 1 | Data bus write strobe |
| bus_wdata | output | 8 | Data bus write data |
| bus_rdata | input | 8 | Data bus read data, combinational |
| sp_value | output | 16 | Current stack pointer |

## Verification
The bench drives each request half a cycle before the accepting edge. It samples op_ready and the strobes half a cycle after that edge, when the first cycle must be silent. It samples bus address, strobes and pointer enables one cycle later, in the second cycle. Register, memory and stack pointer contents are read half a cycle after the edge that closes the second cycle, which is two edges after acceptance. Requests injected during the first cycle are followed through the same window, and then for a further two cycles, to show that nothing changed.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

   typedef enum logic [2:0] {
      K_LD   = 3'd0,
      K_ST   = 3'd1,
      K_PUSH = 3'd2,
      K_POP  = 3'd3,
      K_IN   = 3'd4,
      K_OUT  = 3'd5
   } op_kind_e;

   typedef enum logic [1:0] {
      M_PLAIN   = 2'd0,
      M_PREDEC  = 2'd1,
      M_POSTINC = 2'd2
   } ptr_mode_e;

   typedef enum logic [2:0] {
      RG_REG,
      RG_IO,
      RG_XIO,
      RG_SRAM,
      RG_VOID
   } region_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ADDR,
      S_ACC
   } agu_state_e;

endpackage

// File: rtl/ptr_agu_decode.sv
module ptr_agu_decode
   import ptr_agu_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned REG_SPAN   = 32,
   parameter int unsigned IO_SPAN    = 32,
   parameter int unsigned SRAM_BASE  = 256,
   parameter int unsigned SRAM_BYTES = 1024
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic              on_bus
);
   localparam int unsigned IO_LO    = REG_SPAN;
   localparam int unsigned IO_HI    = REG_SPAN + IO_SPAN;
   localparam int unsigned SRAM_END = SRAM_BASE + SRAM_BYTES;

   logic [31:0] a32;
   logic        beyond;

   assign a32 = 32'(addr);

   // Pick the upper-limit comparator only when SRAM leaves a hole at the top.
   generate
      if (SRAM_END >= (32'd1 << ADDR_W)) begin : g_full_map
         assign beyond = 1'b0;
      end else begin : g_part_map
         assign beyond = (a32 >= SRAM_END);
      end
   endgenerate

   always_comb begin
      if (a32 < IO_LO)            region = RG_REG;
      else if (a32 < IO_HI)       region = RG_IO;
      else if (a32 < SRAM_BASE)   region = RG_XIO;
      else if (beyond)            region = RG_VOID;
      else                        region = RG_SRAM;
   end

   assign on_bus = (region == RG_IO) || (region == RG_XIO) || (region == RG_SRAM);

endmodule

// File: rtl/ptr_agu_ptr_calc.sv
module ptr_agu_ptr_calc
   import ptr_agu_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_PTRS = 3,
   parameter int unsigned PTR_BASE = 26,
   parameter int unsigned REG_AW   = 5,
   parameter int unsigned SEL_W    = 2
) (
   input  logic [SEL_W-1:0]    sel,
   input  ptr_mode_e           mode,
   input  logic [DATA_W-1:0]   lo_byte,
   input  logic [DATA_W-1:0]   hi_byte,
   output logic [REG_AW-1:0]   lo_idx,
   output logic [REG_AW-1:0]   hi_idx,
   output logic [2*DATA_W-1:0] ea,
   output logic [2*DATA_W-1:0] nxt,
   output logic                wr
);
   localparam int unsigned PW = 2 * DATA_W;

   logic [REG_AW-1:0] lo_tab [NUM_PTRS];
   logic [PW-1:0]     cur;

   generate
      for (genvar g = 0; g < NUM_PTRS; g++) begin : g_pair
         assign lo_tab[g] = REG_AW'(PTR_BASE + 2 * g);
      end
   endgenerate

   always_comb begin
      lo_idx = lo_tab[0];
      for (int i = 0; i < NUM_PTRS; i++) begin
         if (sel == SEL_W'(i)) lo_idx = lo_tab[i];
      end
   end

   assign hi_idx = lo_idx | REG_AW'(1);
   assign cur    = {hi_byte, lo_byte};

   always_comb begin
      unique case (mode)
         M_PREDEC: begin
            ea  = cur - PW'(1);
            nxt = cur - PW'(1);
            wr  = 1'b1;
         end
         M_POSTINC: begin
            ea  = cur;
            nxt = cur + PW'(1);
            wr  = 1'b1;
         end
         default: begin
            ea  = cur;
            nxt = cur;
            wr  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ptr_agu_sp.sv
module ptr_agu_sp #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned SP_RESET = 16'h04FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_commit,
   input  logic              pop_commit,
   output logic [ADDR_W-1:0] sp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sp <= ADDR_W'(SP_RESET);
      else if (push_commit)  sp <= sp - ADDR_W'(1);
      else if (pop_commit)   sp <= sp + ADDR_W'(1);
   end

   a_r8_push_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
      push_commit |=> (sp == $past(sp) - ADDR_W'(1)));

   a_r9_pop_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
      pop_commit |=> (sp == $past(sp) + ADDR_W'(1)));

   a_r8_sp_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_commit && !pop_commit) |=> $stable(sp));

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import ptr_agu_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned NUM_REGS   = 32,
   parameter int unsigned IO_SPAN    = 32,
   parameter int unsigned NUM_PTRS   = 3,
   parameter int unsigned PTR_BASE   = 26,
   parameter int unsigned SRAM_BASE  = 256,
   parameter int unsigned SRAM_BYTES = 1024
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        op_valid,
   input  logic [2:0]                  op_kind,
   input  logic [$clog2(NUM_PTRS)-1:0] op_ptr,
   input  logic [1:0]                  op_mode,
   input  logic [$clog2(NUM_REGS)-1:0] op_reg,
   input  logic [$clog2(IO_SPAN)-1:0]  op_io,
   output logic                        op_ready,
   output logic [$clog2(NUM_REGS)-1:0] rf_ptr_lo_addr,
   output logic [$clog2(NUM_REGS)-1:0] rf_ptr_hi_addr,
   input  logic [DATA_W-1:0]           rf_ptr_lo_data,
   input  logic [DATA_W-1:0]           rf_ptr_hi_data,
   output logic [$clog2(NUM_REGS)-1:0] rf_rd_addr,
   input  logic [DATA_W-1:0]           rf_rd_data,
   output logic                        rf_dw_en,
   output logic [$clog2(NUM_REGS)-1:0] rf_dw_addr,
   output logic [DATA_W-1:0]           rf_dw_data,
   output logic                        rf_pw_lo_en,
   output logic                        rf_pw_hi_en,
   output logic [ADDR_W-1:0]           rf_pw_data,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic                        bus_re,
   output logic                        bus_we,
   output logic [DATA_W-1:0]           bus_wdata,
   input  logic [DATA_W-1:0]           bus_rdata,
   output logic [ADDR_W-1:0]           sp_value
);
   localparam int unsigned REG_AW   = $clog2(NUM_REGS);
   localparam int unsigned IO_AW    = $clog2(IO_SPAN);
   localparam int unsigned SEL_W    = $clog2(NUM_PTRS);
   localparam int unsigned IO_LO    = NUM_REGS;
   localparam int unsigned SRAM_END = SRAM_BASE + SRAM_BYTES;
   localparam int unsigned SP_TOP   = SRAM_END - 1;

   // Elaboration-time parameter checks
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ptr_agu: pointer pair must span the address width");
      end
      if ((32'd1 << REG_AW) != NUM_REGS) begin : g_bad_regs
         $error("ptr_agu: register count must be a power of two");
      end
      if ((32'd1 << IO_AW) != IO_SPAN) begin : g_bad_io
         $error("ptr_agu: short I/O span must be a power of two");
      end
      if (PTR_BASE + 2 * NUM_PTRS > NUM_REGS || (PTR_BASE % 2) != 0) begin : g_bad_ptr
         $error("ptr_agu: pointer pairs must be even-aligned inside the register file");
      end
      if (SRAM_BASE < NUM_REGS + IO_SPAN || SRAM_END > (32'd1 << ADDR_W)) begin : g_bad_map
         $error("ptr_agu: SRAM window overlaps the register or I/O windows or exceeds the space");
      end
   endgenerate

   // Operation capture and two-phase sequencing
   agu_state_e        state;
   op_kind_e          q_kind;
   ptr_mode_e         q_mode;
   logic [SEL_W-1:0]  q_sel;
   logic [REG_AW-1:0] q_reg;
   logic [IO_AW-1:0]  q_io;
   logic              accept;

   assign op_ready = (state != S_ADDR);
   assign accept   = op_valid && op_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
      end else begin
         unique case (state)
            S_ADDR:  state <= S_ACC;
            default: state <= accept ? S_ADDR : S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_kind <= K_LD;
         q_mode <= M_PLAIN;
         q_sel  <= '0;
         q_reg  <= '0;
         q_io   <= '0;
      end else if (accept) begin
         q_kind <= op_kind_e'(op_kind);
         q_mode <= ptr_mode_e'(op_mode);
         q_sel  <= op_ptr;
         q_reg  <= op_reg;
         q_io   <= op_io;
      end
   end

   // Phase 1: pointer read and effective address
   logic [ADDR_W-1:0] ptr_ea;
   logic [ADDR_W-1:0] ptr_nxt;
   logic              ptr_wr;
   logic [ADDR_W-1:0] sp;
   logic              is_ptr_op;
   logic [ADDR_W-1:0] ea_d;

   ptr_agu_ptr_calc #(
      .DATA_W   (DATA_W),
      .NUM_PTRS (NUM_PTRS),
      .PTR_BASE (PTR_BASE),
      .REG_AW   (REG_AW),
      .SEL_W    (SEL_W)
   ) u_ptr_calc (
      .sel     (q_sel),
      .mode    (q_mode),
      .lo_byte (rf_ptr_lo_data),
      .hi_byte (rf_ptr_hi_data),
      .lo_idx  (rf_ptr_lo_addr),
      .hi_idx  (rf_ptr_hi_addr),
      .ea      (ptr_ea),
      .nxt     (ptr_nxt),
      .wr      (ptr_wr)
   );

   assign is_ptr_op = (q_kind == K_LD) || (q_kind == K_ST);

   always_comb begin
      unique case (q_kind)
         K_LD, K_ST:  ea_d = ptr_ea;
         K_PUSH:      ea_d = sp;
         K_POP:       ea_d = sp + ADDR_W'(1);
         K_IN, K_OUT: ea_d = ADDR_W'(IO_LO) + ADDR_W'(q_io);
         default:     ea_d = sp;
      endcase
   end

   logic [ADDR_W-1:0] a_ea;
   logic [ADDR_W-1:0] a_nxt;
   logic              a_ptr_wr;
   logic [DATA_W-1:0] a_sdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_ea     <= '0;
         a_nxt    <= '0;
         a_ptr_wr <= 1'b0;
         a_sdata  <= '0;
      end else if (state == S_ADDR) begin
         a_ea     <= ea_d;
         a_nxt    <= ptr_nxt;
         a_ptr_wr <= is_ptr_op && ptr_wr;
         a_sdata  <= rf_rd_data;
      end
   end

   // Phase 2: region routing, bus strobes and register-file writes
   region_e region;
   logic    on_bus;
   logic    in_acc;
   logic    is_load;
   logic    is_store;
   logic [DATA_W-1:0] ld_data;

   ptr_agu_decode #(
      .ADDR_W     (ADDR_W),
      .REG_SPAN   (NUM_REGS),
      .IO_SPAN    (IO_SPAN),
      .SRAM_BASE  (SRAM_BASE),
      .SRAM_BYTES (SRAM_BYTES)
   ) u_decode (
      .addr   (a_ea),
      .region (region),
      .on_bus (on_bus)
   );

   assign in_acc   = (state == S_ACC);
   assign is_load  = (q_kind == K_LD) || (q_kind == K_POP) || (q_kind == K_IN);
   assign is_store = (q_kind == K_ST) || (q_kind == K_PUSH) || (q_kind == K_OUT);

   assign rf_rd_addr = in_acc ? a_ea[REG_AW-1:0] : q_reg;

   always_comb begin
      if (region == RG_REG) ld_data = rf_rd_data;
      else if (on_bus)      ld_data = bus_rdata;
      else                  ld_data = '0;
   end

   assign bus_addr  = a_ea;
   assign bus_wdata = a_sdata;
   assign bus_re    = in_acc && is_load && on_bus;
   assign bus_we    = in_acc && is_store && on_bus;

   assign rf_dw_en   = in_acc && (is_load || (is_store && region == RG_REG));
   assign rf_dw_addr = is_load ? q_reg : a_ea[REG_AW-1:0];
   assign rf_dw_data = is_load ? ld_data : a_sdata;

   // A data write into a pointer byte takes precedence over the write-back.
   assign rf_pw_lo_en = in_acc && a_ptr_wr && !(rf_dw_en && rf_dw_addr == rf_ptr_lo_addr);
   assign rf_pw_hi_en = in_acc && a_ptr_wr && !(rf_dw_en && rf_dw_addr == rf_ptr_hi_addr);
   assign rf_pw_data  = a_nxt;

   ptr_agu_sp #(
      .ADDR_W   (ADDR_W),
      .SP_RESET (SP_TOP)
   ) u_sp (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_commit (in_acc && q_kind == K_PUSH),
      .pop_commit  (in_acc && q_kind == K_POP),
      .sp          (sp)
   );

   assign sp_value = sp;

   // Assertions
   a_r5_strobe_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re || bus_we) |-> !$past(op_ready));

   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_re && bus_we));

   a_r11_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_ready |=> op_ready);

   a_r7_bus_in_map: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re || bus_we) |-> (32'(bus_addr) >= IO_LO && 32'(bus_addr) < SRAM_END));

   a_r10_lo_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_dw_en && rf_pw_lo_en) |-> (rf_dw_addr != rf_ptr_lo_addr));

   a_r10_hi_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_dw_en && rf_pw_hi_en) |-> (rf_dw_addr != rf_ptr_hi_addr));

   a_r3_predec_writes_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ((rf_pw_lo_en || rf_pw_hi_en) && q_mode == M_PREDEC) |-> (rf_pw_data == bus_addr));

   a_r4_postinc_writes_next: assert property (@(posedge clk) disable iff (!rst_n)
      ((rf_pw_lo_en || rf_pw_hi_en) && q_mode == M_POSTINC) |-> (rf_pw_data == bus_addr + ADDR_W'(1)));

   a_r2_plain_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (q_mode == M_PLAIN) |-> !(rf_pw_lo_en || rf_pw_hi_en));

endmodule

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_N      = 16'h0500;

   localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_PUSH = 3'd2,
                          K_POP = 3'd3, K_IN = 3'd4, K_OUT = 3'd5;
   localparam logic [1:0] M_PL = 2'd0, M_PD = 2'd1, M_PI = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_kind = '0;
   logic [1:0]  op_ptr = '0;
   logic [1:0]  op_mode = '0;
   logic [4:0]  op_reg = '0;
   logic [4:0]  op_io = '0;
   logic        op_ready;
   logic [4:0]  rf_ptr_lo_addr, rf_ptr_hi_addr, rf_rd_addr, rf_dw_addr;
   logic [7:0]  rf_ptr_lo_data, rf_ptr_hi_data, rf_rd_data, rf_dw_data;
   logic        rf_dw_en, rf_pw_lo_en, rf_pw_hi_en;
   logic [15:0] rf_pw_data, bus_addr, sp_value;
   logic        bus_re, bus_we;
   logic [7:0]  bus_wdata, bus_rdata;

   logic [7:0]  rf  [32];
   logic [7:0]  mem [MEM_N];

   logic        pk_rf_en = 1'b0, pk_mem_en = 1'b0;
   logic [4:0]  pk_rf_i = '0;
   logic [15:0] pk_mem_i = '0;
   logic [7:0]  pk_v = '0;

   int checks = 0;
   int failures = 0;

   logic        g_addr_ready, g_addr_strobe, g_acc_re, g_acc_we, g_pw_any;
   logic [15:0] g_acc_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptr_agu u_ptr_agu (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_ptr(op_ptr), .op_mode(op_mode), .op_reg(op_reg), .op_io(op_io),
      .op_ready(op_ready), .rf_ptr_lo_addr(rf_ptr_lo_addr),
      .rf_ptr_hi_addr(rf_ptr_hi_addr), .rf_ptr_lo_data(rf_ptr_lo_data),
      .rf_ptr_hi_data(rf_ptr_hi_data), .rf_rd_addr(rf_rd_addr),
      .rf_rd_data(rf_rd_data), .rf_dw_en(rf_dw_en), .rf_dw_addr(rf_dw_addr),
      .rf_dw_data(rf_dw_data), .rf_pw_lo_en(rf_pw_lo_en),
      .rf_pw_hi_en(rf_pw_hi_en), .rf_pw_data(rf_pw_data),
      .bus_addr(bus_addr), .bus_re(bus_re), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sp_value(sp_value)
   );

   // Register-file and memory models; undriven space floats to 0xC3
   assign rf_ptr_lo_data = rf[rf_ptr_lo_addr];
   assign rf_ptr_hi_data = rf[rf_ptr_hi_addr];
   assign rf_rd_data     = rf[rf_rd_addr];
   assign bus_rdata      = (32'(bus_addr) < MEM_N) ? mem[bus_addr] : 8'hC3;

   initial begin
      for (int i = 0; i < 32; i++) rf[i] = 8'h00;
      for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
   end

   // Pointer write-back is applied after the data write so a missed
   // precedence shows up as a lost loaded byte.
   always @(posedge clk) begin
      if (pk_rf_en)  rf[pk_rf_i] <= pk_v;
      if (pk_mem_en) mem[pk_mem_i] <= pk_v;
      if (rf_dw_en)  rf[rf_dw_addr] <= rf_dw_data;
      if (rf_pw_lo_en) rf[rf_ptr_lo_addr] <= rf_pw_data[7:0];
      if (rf_pw_hi_en) rf[rf_ptr_hi_addr] <= rf_pw_data[15:8];
      if (bus_we && 32'(bus_addr) < MEM_N) mem[bus_addr] <= bus_wdata;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic poke_rf(input logic [4:0] i, input logic [7:0] v);
      @(negedge clk); pk_rf_en = 1'b1; pk_rf_i = i; pk_v = v;
      @(negedge clk); pk_rf_en = 1'b0;
   endtask

   task automatic poke_mem(input logic [15:0] i, input logic [7:0] v);
      @(negedge clk); pk_mem_en = 1'b1; pk_mem_i = i; pk_v = v;
      @(negedge clk); pk_mem_en = 1'b0;
   endtask

   task automatic set_ptr(input int pair, input logic [15:0] v);
      poke_rf(5'(26 + 2*pair), v[7:0]);
      poke_rf(5'(27 + 2*pair), v[15:8]);
   endtask

   // Issue one operation; sample the first cycle, the second cycle, then results.
   task automatic run_op(input logic [2:0] kind, input logic [1:0] sel, input logic [1:0] mode,
                         input logic [4:0] rg, input logic [4:0] io, input bit inject);
      @(negedge clk);
      op_valid = 1'b1; op_kind = kind; op_ptr = sel; op_mode = mode; op_reg = rg; op_io = io;
      @(negedge clk);
      g_addr_ready  = op_ready;
      g_addr_strobe = bus_re | bus_we | rf_dw_en | rf_pw_lo_en | rf_pw_hi_en;
      if (inject) begin
         op_valid = 1'b1; op_kind = K_ST; op_ptr = 2'd0; op_mode = M_PL; op_reg = 5'd1;
      end else begin
         op_valid = 1'b0;
      end
      @(negedge clk);
      op_valid   = 1'b0;
      g_acc_addr = bus_addr;
      g_acc_re   = bus_re;
      g_acc_we   = bus_we;
      g_pw_any   = rf_pw_lo_en | rf_pw_hi_en;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R5 ready after reset", 32'(op_ready), 32'd1);
      check("R5 no strobe after reset", 32'(bus_re | bus_we), 32'd0);
      check("R8 stack pointer reset", 32'(sp_value), 32'h04FF);
   endtask

   task automatic t_short_io;
      poke_rf(5'd3, 8'hA5);
      run_op(K_OUT, 2'd0, M_PL, 5'd3, 5'd5, 1'b0);
      check("R1 out address", 32'(g_acc_addr), 32'h0025);
      check("R1 out strobe", 32'(g_acc_we), 32'd1);
      check("R1 out data", 32'(mem[16'h0025]), 32'hA5);
      poke_mem(16'h003F, 8'h4D);
      run_op(K_IN, 2'd0, M_PL, 5'd4, 5'd31, 1'b0);
      check("R1 in address", 32'(g_acc_addr), 32'h003F);
      check("R1 in data", 32'(rf[4]), 32'h4D);
   endtask

   task automatic t_plain;
      set_ptr(1, 16'h0123);
      poke_mem(16'h0123, 8'h77);
      run_op(K_LD, 2'd1, M_PL, 5'd0, 5'd0, 1'b0);
      check("R5 not ready in first cycle", 32'(g_addr_ready), 32'd0);
      check("R5 quiet first cycle", 32'(g_addr_strobe), 32'd0);
      check("R2 plain address", 32'(g_acc_addr), 32'h0123);
      check("R2 plain read strobe", 32'(g_acc_re), 32'd1);
      check("R2 plain data", 32'(rf[0]), 32'h77);
      check("R2 no write-back", 32'(g_pw_any), 32'd0);
      check("R2 pair unchanged", 32'({rf[29], rf[28]}), 32'h0123);
   endtask

   task automatic t_predec;
      set_ptr(0, 16'h0201);
      poke_rf(5'd5, 8'h3C);
      run_op(K_ST, 2'd0, M_PD, 5'd5, 5'd0, 1'b0);
      check("R3 predec address", 32'(g_acc_addr), 32'h0200);
      check("R3 predec stored", 32'(mem[16'h0200]), 32'h3C);
      check("R3 predec pointer", 32'({rf[27], rf[26]}), 32'h0200);
   endtask

   task automatic t_postinc;
      set_ptr(2, 16'h01FF);
      poke_mem(16'h01FF, 8'h61);
      run_op(K_LD, 2'd2, M_PI, 5'd6, 5'd0, 1'b0);
      check("R4 postinc address", 32'(g_acc_addr), 32'h01FF);
      check("R4 postinc data", 32'(rf[6]), 32'h61);
      check("R4 postinc pointer carry", 32'({rf[31], rf[30]}), 32'h0200);
   endtask

   task automatic t_regspace;
      set_ptr(0, 16'h0007);
      poke_rf(5'd7, 8'h99);
      run_op(K_LD, 2'd0, M_PL, 5'd8, 5'd0, 1'b0);
      check("R6 register load", 32'(rf[8]), 32'h99);
      check("R6 no bus on register load", 32'(g_acc_re | g_acc_we), 32'd0);
      set_ptr(0, 16'h000A);
      poke_rf(5'd9, 8'h42);
      run_op(K_ST, 2'd0, M_PL, 5'd9, 5'd0, 1'b0);
      check("R6 register store", 32'(rf[10]), 32'h42);
      check("R6 no bus on register store", 32'(g_acc_re | g_acc_we), 32'd0);
   endtask

   task automatic t_void;
      set_ptr(2, 16'h0600);
      poke_rf(5'd11, 8'h55);
      run_op(K_LD, 2'd2, M_PL, 5'd11, 5'd0, 1'b0);
      check("R7 void load zero", 32'(rf[11]), 32'h00);
      check("R7 void no read strobe", 32'(g_acc_re), 32'd0);
      set_ptr(2, 16'h0700);
      poke_rf(5'd12, 8'hE1);
      run_op(K_ST, 2'd2, M_PL, 5'd12, 5'd0, 1'b0);
      check("R7 void no write strobe", 32'(g_acc_we), 32'd0);
   endtask

   task automatic t_stack;
      poke_rf(5'd12, 8'h5A);
      run_op(K_PUSH, 2'd0, M_PL, 5'd12, 5'd0, 1'b0);
      check("R8 push address", 32'(g_acc_addr), 32'h04FF);
      check("R8 push data", 32'(mem[16'h04FF]), 32'h5A);
      check("R8 push decrements", 32'(sp_value), 32'h04FE);
      poke_rf(5'd13, 8'h6B);
      run_op(K_PUSH, 2'd0, M_PL, 5'd13, 5'd0, 1'b0);
      check("R8 second push", 32'(mem[16'h04FE]), 32'h6B);
      check("R8 sp after two pushes", 32'(sp_value), 32'h04FD);
      run_op(K_POP, 2'd0, M_PL, 5'd14, 5'd0, 1'b0);
      check("R9 pop address", 32'(g_acc_addr), 32'h04FE);
      check("R9 pop data", 32'(rf[14]), 32'h6B);
      check("R9 pop increments", 32'(sp_value), 32'h04FE);
      run_op(K_POP, 2'd0, M_PL, 5'd15, 5'd0, 1'b0);
      check("R9 second pop data", 32'(rf[15]), 32'h5A);
      check("R9 sp restored", 32'(sp_value), 32'h04FF);
   endtask

   task automatic t_conflict;
      set_ptr(0, 16'h01FF);
      poke_mem(16'h01FF, 8'hEE);
      run_op(K_LD, 2'd0, M_PI, 5'd26, 5'd0, 1'b0);
      check("R10 low byte keeps load", 32'(rf[26]), 32'hEE);
      check("R10 high byte updated", 32'(rf[27]), 32'h02);
      set_ptr(0, 16'h0300);
      poke_mem(16'h02FF, 8'h9D);
      run_op(K_LD, 2'd0, M_PD, 5'd27, 5'd0, 1'b0);
      check("R10 high byte keeps load", 32'(rf[27]), 32'h9D);
      check("R10 low byte updated", 32'(rf[26]), 32'hFF);
   endtask

   task automatic t_ignore;
      set_ptr(0, 16'h0210);
      poke_mem(16'h0210, 8'h11);
      poke_rf(5'd1, 8'h22);
      run_op(K_LD, 2'd0, M_PL, 5'd2, 5'd0, 1'b1);
      check("R11 accepted op result", 32'(rf[2]), 32'h11);
      check("R11 accepted op address", 32'(g_acc_addr), 32'h0210);
      repeat (2) @(negedge clk);
      check("R11 injected store dropped", 32'(mem[16'h0210]), 32'h11);
      check("R11 block idle afterwards", 32'(op_ready & ~(bus_re | bus_we)), 32'd1);
   endtask

   task automatic t_wrap;
      set_ptr(0, 16'h0000);
      poke_rf(5'd16, 8'h3A);
      run_op(K_LD, 2'd0, M_PD, 5'd16, 5'd0, 1'b0);
      check("R12 wrapped address", 32'(g_acc_addr), 32'hFFFF);
      check("R12 wrapped pointer", 32'({rf[27], rf[26]}), 32'hFFFF);
      check("R12 wrapped load zero", 32'(rf[16]), 32'h00);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short_io();
      t_plain();
      t_predec();
      t_postinc();
      t_regspace();
      t_void();
      t_stack();
      t_conflict();
      t_ignore();
      t_wrap();
      finish_run();
   end

endmodule